// File: doc/BRIEF.md
# Daisy-Chain Serial DAC Update Controller

This block sits on the host side of a chain of cascaded 10-bit serial DACs that share one active-low chip select. Each device's output pin feeds the next device's input, so a bit entering the first device reaches the last one only after passing through every device's 16-bit shift stage. A client hands the controller one code per device in a single valid/ready transfer. The controller packs each code into a 16-bit word, opens one chip-select window and streams every word in SPI mode 0. The word for the device farthest along the chain goes first. The controller then closes the window, and all devices latch their words on the same chip-select rise.

All serial timing is counted in system clocks and set through plain configuration inputs: the serial clock high and low times, the lead time from chip select falling to the first rising edge, and the minimum chip-select high time between windows. The number of devices in use is also configurable. Back-pressure is simple: `req_ready` is high only when the controller is idle. A transfer is taken on any cycle where `req_valid` and `req_ready` are both high. The codes are captured in that cycle, so the client may change them afterwards. `req_ready` stays low until the chip-select high time after the window has passed. It returns together with a one-cycle `done` pulse.

During each window the controller also samples the chain's returned data on every rising serial clock edge. After a full window, the bits leaving the last device are the previous window's stream. The controller compares them with that stream and reports any difference on `mismatch`.

Top module: `dac_chain_ctrl`

## Requirements
- R1: After reset `dac_cs_n` is 1, `dac_sclk` is 0, `req_ready` is 1, `done` is 0 and `mismatch` is 0.
- R2: Each device word is 16 bits sent MSB first: four zero pad bits (word bits 15..12), the 10-bit code (word bits 11..2), then two zero bits (word bits 1..0).
- R3: Device i takes its code from `req_codes[10*i+9:10*i]`. Device 0 is wired to `dac_mosi`. In one chip-select window the word for device `chain_len-1` is sent first and device 0's word last, using exactly 16*`chain_len` rising serial clock edges.
- R4: `dac_sclk` is low whenever `dac_cs_n` is high. `dac_mosi` changes only while `dac_sclk` is low and holds steady for every cycle in which `dac_sclk` is high.
- R5: `dac_cs_n` changes only in a cycle where `dac_sclk` is low and was low in the previous cycle.
- R6: Every serial clock high phase lasts `hi_cyc` system clocks and every low phase lasts `lo_cyc`. The first rising edge comes `lead_cyc` clocks after chip select falls. Chip select rises `lo_cyc` clocks after the last falling edge. A setting of 0 counts as 1.
- R7: `req_ready` is 1 only while idle. After an accepted request it stays low for exactly lead + 16*`chain_len`*(hi + lo) + gap system clocks, using the effective values of R6, where gap is `gap_cyc`, the chip-select high time.
- R8: `done` is a single-cycle pulse raised in the cycle `req_ready` returns to 1.
- R9: At `done`, `mismatch` is 1 exactly when the previous window had the same `chain_len` and some bit sampled from `dac_miso` on a rising edge differed from the bit the previous window sent at the same position. Otherwise it is 0. It holds its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_len | input | 3 | Number of devices in use (1..N_DEV) |
| hi_cyc | input | 8 | Serial clock high time in system clocks |
| lo_cyc | input | 8 | Serial clock low time in system clocks |
| lead_cyc | input | 8 | Chip select low to first rising edge, in system clocks |
| gap_cyc | input | 8 | Minimum chip-select high time, in system clocks |
| req_valid | input | 1 | Request holds one code per device |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_codes | input | 40 | Packed codes, device i in bits 10*i+9..10*i |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_mosi | output | 1 | Serial data to device 0 |
| dac_cs_n | output | 1 | Shared chip select, active low |
| dac_miso | input | 1 | Data returned from the last device in use |
| done | output | 1 | One-cycle pulse when an update has finished |
| mismatch | output | 1 | Read-back comparison result, valid at done |

## Verification
The bench drives a chain of behavioural device models, so a word in the wrong order or slot lands in the wrong device, and a packing error shows up as nonzero pad bits. Directed frames use all-ones codes, all-zero codes and alternating bit patterns with the minimum timing settings. Random frames vary the chain length from one to four devices and every timing setting, which separates the phase-length arithmetic from the bit count. The read-back check runs three ways: clean repeats, where mismatch must stay low; a deliberately inverted return path, where it must rise; and a change of chain length, where it must stay low because the comparison is disabled.

// File: rtl/dac_chain_pkg.sv
package dac_chain_pkg;
  localparam int CODE_W = 10;
  localparam int PAD_W  = 4;
  localparam int SUB_W  = 2;
  localparam int WORD_W = PAD_W + CODE_W + SUB_W;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_HIGH,
    PH_LOW,
    PH_TAIL,
    PH_GAP
  } phase_e;

  function automatic logic [WORD_W-1:0] pack_word(input logic [CODE_W-1:0] code);
    return {{PAD_W{1'b0}}, code, {SUB_W{1'b0}}};
  endfunction
endpackage

// File: rtl/dac_frame_pack.sv
module dac_frame_pack
  import dac_chain_pkg::*;
#(
  parameter int N_DEV = 4
) (
  input  logic [N_DEV*CODE_W-1:0] codes,
  output logic [N_DEV*WORD_W-1:0] frame
);
  for (genvar d = 0; d < N_DEV; d++) begin : g_word
    assign frame[d*WORD_W +: WORD_W] = pack_word(codes[d*CODE_W +: CODE_W]);
  end
endmodule

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (load_val == '0) ? CNT_W'(1) : load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expire = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/dac_readback_chk.sv
module dac_readback_chk #(
  parameter int FRAME_W = 64,
  parameter int LEN_W   = 3,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] old_frame,
  input  logic [LEN_W-1:0]   old_len,
  input  logic [LEN_W-1:0]   new_len,
  input  logic               sample,
  input  logic [IDX_W-1:0]   sample_idx,
  input  logic               miso,
  input  logic               finish,
  output logic               mismatch
);
  logic [FRAME_W-1:0] prev_q;
  logic               sent_q;
  logic               en_q;
  logic               err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      sent_q   <= 1'b0;
      en_q     <= 1'b0;
      err_q    <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      if (start) begin
        prev_q <= old_frame;
        en_q   <= sent_q && (old_len == new_len);
        sent_q <= 1'b1;
        err_q  <= 1'b0;
      end else if (sample && en_q && (miso != prev_q[sample_idx])) begin
        err_q <= 1'b1;
      end
      if (finish) begin
        mismatch <= en_q && err_q;
      end
    end
  end
endmodule

// File: rtl/dac_chain_ctrl.sv
module dac_chain_ctrl
  import dac_chain_pkg::*;
#(
  parameter int N_DEV = 4,
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(N_DEV+1)-1:0] chain_len,
  input  logic [CNT_W-1:0]        hi_cyc,
  input  logic [CNT_W-1:0]        lo_cyc,
  input  logic [CNT_W-1:0]        lead_cyc,
  input  logic [CNT_W-1:0]        gap_cyc,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [N_DEV*CODE_W-1:0] req_codes,
  output logic                    dac_sclk,
  output logic                    dac_mosi,
  output logic                    dac_cs_n,
  input  logic                    dac_miso,
  output logic                    done,
  output logic                    mismatch
);
  localparam int LEN_W   = $clog2(N_DEV+1);
  localparam int FRAME_W = N_DEV * WORD_W;
  localparam int IDX_W   = $clog2(FRAME_W);

  phase_e             phase_q;
  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] packed_frame;
  logic [LEN_W-1:0]   len_q;
  logic [LEN_W-1:0]   len_eff;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   first_idx;
  logic [IDX_W:0]     bit_total;
  logic               sclk_q;
  logic               cs_n_q;
  logic               done_q;
  logic               accept;
  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic               tmr_exp;
  logic               sample;
  logic               finish;

  dac_frame_pack #(.N_DEV(N_DEV)) u_pack (
    .codes(req_codes),
    .frame(packed_frame)
  );

  // Chain length kept within 1..N_DEV.
  always_comb begin
    if (chain_len == '0)                      len_eff = LEN_W'(1);
    else if (chain_len > LEN_W'(N_DEV))       len_eff = LEN_W'(N_DEV);
    else                                      len_eff = chain_len;
  end

  assign bit_total = (IDX_W+1)'(len_eff) << 4;
  assign first_idx = IDX_W'(bit_total - (IDX_W+1)'(1));

  assign accept = (phase_q == PH_IDLE) && req_valid;
  assign sample = tmr_exp && ((phase_q == PH_LEAD) || (phase_q == PH_LOW));
  assign finish = tmr_exp && (phase_q == PH_GAP);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      PH_IDLE: begin tmr_load = accept;  tmr_val = lead_cyc; end
      PH_LEAD: begin tmr_load = tmr_exp; tmr_val = hi_cyc;   end
      PH_HIGH: begin tmr_load = tmr_exp; tmr_val = lo_cyc;   end
      PH_LOW:  begin tmr_load = tmr_exp; tmr_val = hi_cyc;   end
      PH_TAIL: begin tmr_load = tmr_exp; tmr_val = gap_cyc;  end
      default: begin tmr_load = 1'b0;    tmr_val = '0;       end
    endcase
  end

  dac_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expire  (tmr_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      frame_q <= '0;
      len_q   <= LEN_W'(1);
      idx_q   <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (accept) begin
          frame_q <= packed_frame;
          len_q   <= len_eff;
          idx_q   <= first_idx;
          cs_n_q  <= 1'b0;
          phase_q <= PH_LEAD;
        end
        PH_LEAD: if (tmr_exp) begin
          sclk_q  <= 1'b1;
          phase_q <= PH_HIGH;
        end
        PH_HIGH: if (tmr_exp) begin
          sclk_q <= 1'b0;
          if (idx_q == '0) begin
            phase_q <= PH_TAIL;
          end else begin
            idx_q   <= idx_q - IDX_W'(1);
            phase_q <= PH_LOW;
          end
        end
        PH_LOW: if (tmr_exp) begin
          sclk_q  <= 1'b1;
          phase_q <= PH_HIGH;
        end
        PH_TAIL: if (tmr_exp) begin
          cs_n_q  <= 1'b1;
          phase_q <= PH_GAP;
        end
        PH_GAP: if (tmr_exp) begin
          done_q  <= 1'b1;
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  dac_readback_chk #(.FRAME_W(FRAME_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_rb (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .old_frame (frame_q),
    .old_len   (len_q),
    .new_len   (len_eff),
    .sample    (sample),
    .sample_idx(idx_q),
    .miso      (dac_miso),
    .finish    (finish),
    .mismatch  (mismatch)
  );

  assign req_ready = (phase_q == PH_IDLE);
  assign dac_sclk  = sclk_q;
  assign dac_cs_n  = cs_n_q;
  assign dac_mosi  = frame_q[idx_q];
  assign done      = done_q;
endmodule

// File: rtl/dac_chain_ctrl_chk.sv
module dac_chain_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic dac_sclk,
  input logic dac_mosi,
  input logic dac_cs_n,
  input logic done,
  input logic mismatch
);
  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    dac_cs_n |-> !dac_sclk); // R4
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sclk |-> $stable(dac_mosi)); // R4
  AST_CS_EDGE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_cs_n != $past(dac_cs_n)) |-> (!dac_sclk && !$past(dac_sclk))); // R5
  AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid)); // R7
  AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_cs_n |-> !req_ready); // R7
  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_MISMATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(mismatch)); // R9
endmodule

bind dac_chain_ctrl dac_chain_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .dac_sclk (dac_sclk),
  .dac_mosi (dac_mosi),
  .dac_cs_n (dac_cs_n),
  .done     (done),
  .mismatch (mismatch)
);

// File: tb/dac_dev_model.sv
module dac_dev_model (
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        din,
  output logic        dout,
  output logic [15:0] word
);
  logic [15:0] sr = 16'h0;

  initial begin
    dout = 1'b0;
    word = 16'h0;
  end

  always @(posedge sclk) if (!cs_n) sr <= {sr[14:0], din};
  always @(negedge sclk) if (!cs_n) dout <= sr[15];
  always @(posedge cs_n) word <= sr;
endmodule

// File: tb/sim_dac_chain_ctrl.sv
module sim_dac_chain_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  chain_len = 3'd4;
  logic [7:0]  hi_cyc = 8'd1, lo_cyc = 8'd1, lead_cyc = 8'd1, gap_cyc = 8'd1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [39:0] req_codes = '0;
  logic        dac_sclk, dac_mosi, dac_cs_n, dac_miso;
  logic        done, mismatch;
  logic        inject = 1'b0;
  logic [NDEV-1:0] dout;
  logic [15:0] word [NDEV];

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_chain_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .chain_len(chain_len),
    .hi_cyc(hi_cyc), .lo_cyc(lo_cyc), .lead_cyc(lead_cyc), .gap_cyc(gap_cyc),
    .req_valid(req_valid), .req_ready(req_ready), .req_codes(req_codes),
    .dac_sclk(dac_sclk), .dac_mosi(dac_mosi), .dac_cs_n(dac_cs_n),
    .dac_miso(dac_miso), .done(done), .mismatch(mismatch)
  );

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    dac_dev_model u_dev (
      .sclk(dac_sclk), .cs_n(dac_cs_n),
      .din((d == 0) ? dac_mosi : dout[(d == 0) ? 0 : d-1]),
      .dout(dout[d]), .word(word[d])
    );
  end

  assign dac_miso = dout[chain_len - 3'd1] ^ inject;

  // Waveform monitor
  int  run = 0, rises = 0;
  int  hi_e = 1, lo_e = 1, lead_e = 1;
  bit  t_bad = 0, e_bad = 0, m_bad = 0;
  logic p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dac_sclk != p_sclk || dac_cs_n != p_cs) begin
        if (dac_sclk && !p_sclk) begin
          if (rises == 0) begin if (run != lead_e) t_bad = 1; end
          else if (run != lo_e) t_bad = 1;
          rises++;
        end
        if (!dac_sclk && p_sclk && run != hi_e) t_bad = 1;
        if (dac_cs_n && !p_cs && run != lo_e) t_bad = 1;
        if (dac_cs_n != p_cs && (dac_sclk || p_sclk)) e_bad = 1;
        run = 1;
      end else begin
        run++;
      end
      if (dac_sclk && dac_mosi != p_mosi) m_bad = 1;
      p_sclk = dac_sclk; p_cs = dac_cs_n; p_mosi = dac_mosi;
    end
  end

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [15:0] exp_word(input logic [9:0] c);
    return {4'b0000, c, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  bit have_prev = 0;
  int prev_len = 0;

  task automatic send(input logic [39:0] codes, input int len, input int hi, input int lo,
                      input int lead, input int gap, input bit inj);
    int cnt;
    bit exp_mm;
    @(negedge clk);
    chain_len = 3'(len); hi_cyc = 8'(hi); lo_cyc = 8'(lo);
    lead_cyc = 8'(lead); gap_cyc = 8'(gap);
    hi_e = eff(hi); lo_e = eff(lo); lead_e = eff(lead);
    rises = 0; t_bad = 0; e_bad = 0; m_bad = 0;
    req_codes = codes; inject = inj;
    exp_mm = inj && have_prev && (prev_len == len);
    have_prev = 1; prev_len = len;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_codes = ~codes;
    cnt = 0;
    while (!done) begin
      if (!req_ready) cnt++;
      @(negedge clk);
    end
    chk(cnt == eff(lead) + 16*len*(eff(hi) + eff(lo)) + eff(gap), "R7 busy cycles",
        cnt, eff(lead) + 16*len*(eff(hi) + eff(lo)) + eff(gap));
    for (int d = 0; d < len; d++)
      chk(word[d] == exp_word(codes[d*10 +: 10]), "R2 R3 device word",
          word[d], exp_word(codes[d*10 +: 10]));
    chk(rises == 16*len, "R3 rising edges", rises, 16*len);
    chk(!t_bad, "R6 phase lengths", t_bad, 0);
    chk(!e_bad, "R5 cs edge with sclk low", e_bad, 0);
    chk(!m_bad, "R4 mosi stable while high", m_bad, 0);
    chk(mismatch == exp_mm, "R9 mismatch", mismatch, exp_mm);
    @(negedge clk);
    chk(!done && req_ready, "R8 done single pulse", {done, req_ready}, 2'b01);
    inject = 1'b0;
  endtask

  function automatic logic [39:0] fill(input logic [9:0] a, input logic [9:0] b);
    return {b, a, b, a};
  endfunction

  initial begin
    void'($urandom(32'h5EED));
    #(CLK_PERIOD*3);
    @(negedge clk);
    chk(dac_cs_n && !dac_sclk && req_ready && !done && !mismatch, "R1 reset state",
        {dac_cs_n, dac_sclk, req_ready, done, mismatch}, 5'b10100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dac_cs_n && !dac_sclk && req_ready && !done && !mismatch, "R1 idle after reset",
        {dac_cs_n, dac_sclk, req_ready, done, mismatch}, 5'b10100);
    // Directed corners
    send(fill(10'h3FF, 10'h3FF), 4, 0, 0, 0, 0, 0);   // R6 zero settings, first frame
    send(fill(10'h000, 10'h000), 4, 3, 2, 4, 5, 0);   // R9 clean repeat
    send(fill(10'h2AA, 10'h155), 4, 1, 2, 1, 1, 1);   // R9 inverted return
    send({10'h0, 10'h0, 10'h0, 10'h1A5}, 1, 2, 1, 3, 2, 1); // R9 length changed
    send({10'h3C3, 10'h111, 10'h222, 10'h333}, 4, 1, 1, 1, 3, 0);
    // Random frames
    for (int i = 0; i < 10; i++) begin
      logic [39:0] c;
      int ln;
      c = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
      ln = 1 + ($urandom % 4);
      send(c, ln, $urandom % 5, $urandom % 5, $urandom % 5, $urandom % 5,
           ($urandom % 4) == 0);
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule